// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Operand Inversion

This block is the arithmetic and logic stage of a small integer datapath. It takes two 32-bit operands and a 3-bit operation code and produces a result word, a flag that is high when every result bit is clear, and the top bit of the internal adder. The block has no clock and no state; the outputs follow the inputs within the same cycle.

A decoder turns the operation code into three internal controls: an invert request for the second operand, the adder's carry-in, and a 2-bit selector that picks one of four result sources (bitwise AND, bitwise OR, adder sum, or the less-than bit). Subtraction is done by inverting the second operand and injecting a carry of one, so the same adder serves add, subtract, set-on-less-than and equality compare. The less-than value is the adder's most significant sum bit from the subtraction, with no correction for signed overflow. The logic operations always see the second operand as given.

The adder is a chain of one-bit slices built with a generate loop, so the width is a parameter and the carry ripples from bit 0 to the top bit.

Top module: `alu_ripple_top`

## Requirements
- R1: With op_sel = 0 (add) the result is opa + opb modulo 2^32.
- R2: With op_sel = 1 (subtract) the result is opa - opb modulo 2^32.
- R3: With op_sel = 2 (and) the result is opa & opb; opb is never inverted for this code.
- R4: With op_sel = 3 (or) the result is opa | opb; opb is never inverted for this code.
- R5: With op_sel = 4 (set-less-than) result bit 0 equals bit 31 of opa - opb and bits 31:1 are zero; no overflow correction is applied, so opa = 0x7FFFFFFF, opb = 0xFFFFFFFF gives 1.
- R6: With op_sel = 5 (equality compare) the result is opa - opb and res_zero is 1 exactly when opa equals opb.
- R7: For every operation code res_zero is 1 when all 32 result bits are 0 and 0 otherwise.
- R8: add_sign is bit 31 of the adder output: of opa - opb for codes 1, 4 and 5, and of opa + opb for codes 0, 2, 3, 6 and 7.
- R9: Codes 6 and 7 are unused and behave exactly like code 0 (add).
- R10: The block is purely combinational: a change on any input shows on res, res_zero and add_sign in the same cycle, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 3 | Operation code: 0 add, 1 subtract, 2 and, 3 or, 4 set-less-than, 5 equality compare, 6/7 add |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res | output | 32 | Selected result word |
| res_zero | output | 1 | High when every bit of res is zero |
| add_sign | output | 1 | Most significant bit of the adder sum |

## Verification
A fault in the decoder, such as a dropped carry-in or an invert leaking into the logic operations, appears at res in the same cycle as the faulty code is applied: subtract results come out one short, or and/or results look like they used the complemented operand. A break in the carry chain shows only for operand pairs whose carry crosses the broken slice, which is why random operands are mixed with long-carry corner cases such as all-ones plus one. The less-than and zero paths are checked on equal operands, on operands whose difference overflows, and on every operation code, since the flag must track the result whatever the source.

// File: rtl/alu_ripple_pkg.sv
package alu_ripple_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_SLT  = 3'd4,
    OP_CMPEQ = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } res_sel_e;

  typedef struct packed {
    logic     inv_b;
    logic     carry_in;
    res_sel_e sel;
  } alu_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_ripple_pkg::*;
(
  input  alu_op_e   op,
  output alu_ctrl_t ctrl
);

  always_comb begin
    ctrl.inv_b    = 1'b0;
    ctrl.carry_in = 1'b0;
    ctrl.sel      = SEL_SUM;
    unique case (op)
      OP_SUB, OP_CMPEQ: begin
        ctrl.inv_b    = 1'b1;
        ctrl.carry_in = 1'b1;
        ctrl.sel      = SEL_SUM;
      end
      OP_SLT: begin
        ctrl.inv_b    = 1'b1;
        ctrl.carry_in = 1'b1;
        ctrl.sel      = SEL_LESS;
      end
      OP_AND: ctrl.sel = SEL_AND;
      OP_OR:  ctrl.sel = SEL_OR;
      default: ctrl.sel = SEL_SUM;
    endcase
  end

  // R3 / R4: logic operations must never request operand inversion
  always_comb begin
    if (ctrl.sel == SEL_AND || ctrl.sel == SEL_OR)
      assert_logic_no_invert_R3: assert (ctrl.inv_b == 1'b0 && ctrl.carry_in == 1'b0);
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice (
  input  logic a,
  input  logic b,
  input  logic inv_b,
  input  logic cin,
  output logic sum,
  output logic cout,
  output logic and_o,
  output logic or_o
);

  logic b_eff;

  always_comb begin
    b_eff = b ^ inv_b;
    sum   = a ^ b_eff ^ cin;
    cout  = (a & b_eff) | (a & cin) | (b_eff & cin);
    and_o = a & b;
    or_o  = a | b;
  end

endmodule

// File: rtl/alu_ripple_core.sv
module alu_ripple_core
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             msb_sum
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_v;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;

  assign carry[0] = ctrl.carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_bit_slice u_slice (
      .a     (a[i]),
      .b     (b[i]),
      .inv_b (ctrl.inv_b),
      .cin   (carry[i]),
      .sum   (sum_v[i]),
      .cout  (carry[i+1]),
      .and_o (and_v[i]),
      .or_o  (or_v[i])
    );
  end

  always_comb begin
    unique case (ctrl.sel)
      SEL_AND:  result = and_v;
      SEL_OR:   result = or_v;
      SEL_SUM:  result = sum_v;
      default:  result = {{MSB{1'b0}}, sum_v[MSB]};
    endcase
    zero    = ~|result;
    msb_sum = sum_v[MSB];
  end

  // R5: less-than selection leaves only bit 0 possibly set
  always_comb begin
    if (ctrl.sel == SEL_LESS)
      assert_slt_upper_clear_R5: assert (result[MSB:1] == '0);
  end

endmodule

// File: rtl/alu_ripple_top.sv
module alu_ripple_top
  import alu_ripple_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic             res_zero,
  output logic             add_sign
);

  alu_ctrl_t ctrl;

  alu_op_decode u_decode (
    .op   (alu_op_e'(op_sel)),
    .ctrl (ctrl)
  );

  alu_ripple_core #(.WIDTH(WIDTH)) u_core (
    .a       (opa),
    .b       (opb),
    .ctrl    (ctrl),
    .result  (res),
    .zero    (res_zero),
    .msb_sum (add_sign)
  );

  // Port-level checks against an independent arithmetic model
  always_comb begin
    if (!$isunknown({op_sel, opa, opb})) begin
      if (op_sel == 3'd0)
        assert_add_result_R1: assert (res == opa + opb);
      if (op_sel == 3'd2)
        assert_and_result_R3: assert (res == (opa & opb));
      if (op_sel == 3'd5)
        assert_cmpeq_zero_R6: assert (res_zero == (opa == opb));
      if (op_sel == 3'd1 || op_sel == 3'd4 || op_sel == 3'd5)
        assert_sub_sign_R8: assert (add_sign == ((opa - opb) >> (WIDTH - 1)));
    end
  end

endmodule

// File: tb/test_alu_ripple_top.sv
`timescale 1ns/1ps
module test_alu_ripple_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op_sel;
  logic [31:0] opa, opb;
  logic [31:0] res;
  logic        res_zero, add_sign;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  alu_ripple_top i_alu_ripple_top (
    .op_sel   (op_sel),
    .opa      (opa),
    .opb      (opb),
    .res      (res),
    .res_zero (res_zero),
    .add_sign (add_sign)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] d;
    d = a - b;
    case (op)
      3'd1, 3'd5: return d;              // R2, R6
      3'd2:       return a & b;          // R3
      3'd3:       return a | b;          // R4
      3'd4:       return {31'd0, d[31]}; // R5
      default:    return a + b;          // R1, R9
    endcase
  endfunction

  function automatic logic exp_sign(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] s;
    s = (op == 3'd1 || op == 3'd4 || op == 3'd5) ? a - b : a + b;
    return s[31];
  endfunction

  task automatic check_vec(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    logic [31:0] er;
    @(negedge clk);
    op_sel = op; opa = a; opb = b;
    #1;
    er = exp_res(op, a, b);
    checks++;
    if (res !== er) begin
      fails++;
      $display("FAIL %s res op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, res, er);
    end
    checks++;
    if (res_zero !== (er == 32'd0)) begin
      fails++;
      $display("FAIL R7 %s zero op=%0d actual=%b expected=%b", req, op, res_zero, (er == 32'd0));
    end
    checks++;
    if (add_sign !== exp_sign(op, a, b)) begin
      fails++;
      $display("FAIL R8 %s sign op=%0d actual=%b expected=%b", req, op, add_sign, exp_sign(op, a, b));
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1a2b3c));
    rst_n = 1'b0; op_sel = 3'd0; opa = '0; opb = '0;
    #1;
    // initial state: 0 + 0 gives zero result with zero flag (R1, R7)
    checks++;
    if (res !== 32'd0 || res_zero !== 1'b1) begin
      fails++;
      $display("FAIL R7 initial actual=%h/%b expected=0/1", res, res_zero);
    end
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // directed corners
    check_vec(3'd0, 32'hFFFFFFFF, 32'h00000001, "R1");
    check_vec(3'd0, 32'h7FFFFFFF, 32'h00000001, "R1");
    check_vec(3'd1, 32'h00000000, 32'h00000001, "R2");
    check_vec(3'd1, 32'h12345678, 32'h12345678, "R2");
    check_vec(3'd2, 32'hFFFFFFFF, 32'h0F0F00FF, "R3");
    check_vec(3'd2, 32'hA5A5A5A5, 32'h00000000, "R3");
    check_vec(3'd3, 32'h00000000, 32'h0000F00D, "R4");
    check_vec(3'd3, 32'h00000000, 32'h00000000, "R4");
    check_vec(3'd4, 32'h7FFFFFFF, 32'hFFFFFFFF, "R5");
    check_vec(3'd4, 32'hFFFFFFFF, 32'h00000001, "R5");
    check_vec(3'd4, 32'h00000005, 32'h00000003, "R5");
    check_vec(3'd4, 32'h00000003, 32'h00000003, "R5");
    check_vec(3'd5, 32'hDEADBEEF, 32'hDEADBEEF, "R6");
    check_vec(3'd5, 32'hDEADBEEF, 32'hDEADBEEE, "R6");
    check_vec(3'd6, 32'h80000000, 32'h80000000, "R9");
    check_vec(3'd7, 32'h00000010, 32'hFFFFFFF0, "R9");

    // R10: input change without a clock edge shows at once
    op_sel = 3'd3; opa = 32'h1; opb = 32'h2;
    #0.5;
    checks++;
    if (res !== 32'h3) begin
      fails++;
      $display("FAIL R10 actual=%h expected=%h", res, 32'h3);
    end

    // constrained random over all codes
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  op;
      logic [31:0] a, b;
      op = 3'($urandom_range(0, 7));
      a = $urandom;
      b = (n % 8 == 0) ? a : $urandom;
      check_vec(op, a, b, "R1-R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule